// File: doc/BRIEF.md
# Dual Configurable Threshold Alarm

Two independent alarm monitors watch a bank of sample sources. Each monitor picks one source through a 4-bit code, chooses between the raw and the filtered copy of that source, and on every sample strobe compares either the sample itself or its change over a programmable number of samples against a signed threshold. The threshold word also carries the comparison direction.

A hit sets a sticky status flag, and the flag stays set until the host reads the status word. The block does not compute the source data and has no host interface of its own. The host supplies the control, threshold and span words as plain inputs and pulses a read strobe when it reads the status word. The two flags are ORed and can drive one of two output lines, with the active level programmable.

Top module: `dual_threshold_alarm`

## Requirements
- R1: Source codes 1 to 11 select the source in slot code-1 of the source vectors (1 supply, 2-4 rate X/Y/Z, 5-7 acceleration X/Y/Z, 8 temperature, 9-10 incline, 11 auxiliary converter). Code 0 and codes 12 to 15 disable the monitor, and a disabled monitor never sets its flag. Alarm A takes its code from ctrl_i[11:8] and alarm B from ctrl_i[15:12].
- R2: ctrl_i[4] = 1 selects the filtered source copies and 0 selects the raw copies. Codes 9 and 10 always use the filtered copy, whatever ctrl_i[4] holds.
- R3: In level mode the selected 14-bit two's complement sample is compared signed with threshold bits 13:0 (two's complement). Threshold bit 15 = 1 means "sample greater than threshold" and 0 means "sample less than threshold".
- R4: Rate mode is enabled by ctrl_i[6] for alarm A and ctrl_i[7] for alarm B. The compared value is the current sample minus the sample taken N strobes earlier, where N is the span input, and spans 0 and 1 both mean N = 1. The history records the selected value (0 when disabled) on every strobe. No rate alarm is possible until N strobes have been recorded since reset.
- R5: On the clock edge that captures a strobe whose condition holds, the flag sets. Alarm A is reported in status_o[8] and alarm B in status_o[9]; every other status bit reads 0.
- R6: A status read strobe clears both flags at the next edge. If a sample strobe in the same cycle meets the condition, that flag is set instead.
- R7: A set flag stays set until a read strobe, whatever later samples show.
- R8: With ctrl_i[2] = 0 both lines are low. With ctrl_i[2] = 1, the line chosen by ctrl_i[0] (1 = line 1, 0 = line 0) carries the OR of both flags. It is active high when ctrl_i[1] = 1 and active low when ctrl_i[1] = 0, and the other line is low.
- R9: After reset both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid_i | input | 1 | One-cycle strobe: a new sample set is present |
| src_raw_i | input | NSRC*DW | Raw source samples, slot k-1 for code k |
| src_filt_i | input | NSRC*DW | Filtered source samples, same slots |
| ctrl_i | input | 16 | Alarm control word |
| thr_a_i | input | 16 | Alarm A threshold word: bit 15 is the direction, bits 13:0 the level |
| thr_b_i | input | 16 | Alarm B threshold word |
| span_a_i | input | SPAN_W | Alarm A rate span in samples |
| span_b_i | input | SPAN_W | Alarm B rate span in samples |
| status_rd_i | input | 1 | Status word read strobe (clears flags) |
| status_o | output | 16 | Status word: bit 8 alarm A, bit 9 alarm B |
| alarm_line_o | output | 2 | Alarm output lines |

## Verification
Each flag changes on the first rising edge after the strobe or read that causes the change, because exactly one register sits between the inputs and the flag. The output lines follow the flags and the control word through logic alone, so they update in the same cycle as the flags. The bench drives every input on the falling edge and updates its reference model for the coming rising edge. It then compares status and lines on the next falling edge, exactly one register delay later. The model keeps its own history of selected values and its own fill count, so rate-mode results, including the suppressed ones just after reset, are predicted without looking inside the design.

// File: rtl/dta_pkg.sv
package dta_pkg;
   localparam int CODE_W      = 4;
   localparam int THR_DIR_BIT = 15;
   localparam int STAT_BIT_A  = 8;
   localparam int STAT_BIT_B  = 9;

   typedef enum logic [CODE_W-1:0] {
      SRC_OFF    = 4'd0,
      SRC_SUPPLY = 4'd1,
      SRC_INCL_A = 4'd9,
      SRC_INCL_B = 4'd10,
      SRC_AUX    = 4'd11
   } src_code_e;

   // control word field positions
   localparam int CF_SRC_A_LO = 8;
   localparam int CF_SRC_B_LO = 12;
   localparam int CF_RATE_A   = 6;
   localparam int CF_RATE_B   = 7;
   localparam int CF_FILT     = 4;
   localparam int CF_OUT_EN   = 2;
   localparam int CF_OUT_POL  = 1;
   localparam int CF_OUT_SEL  = 0;

   function automatic logic always_filtered(input logic [CODE_W-1:0] code);
      return (code == SRC_INCL_A) || (code == SRC_INCL_B);
   endfunction
endpackage

// File: rtl/dta_src_mux.sv
module dta_src_mux
   import dta_pkg::*;
#(
   parameter int DW   = 14,
   parameter int NSRC = 11
)(
   input  logic [NSRC*DW-1:0] raw_i,
   input  logic [NSRC*DW-1:0] filt_i,
   input  logic [CODE_W-1:0]  code_i,
   input  logic               filt_sel_i,
   output logic               valid_o,
   output logic [DW-1:0]      value_o
);
   logic [DW-1:0] cand [1:NSRC];

   for (genvar k = 1; k <= NSRC; k++) begin : g_slot
      localparam logic [CODE_W-1:0] KC = CODE_W'(k);
      assign cand[k] = (filt_sel_i || always_filtered(KC)) ?
                       filt_i[k*DW-1 -: DW] : raw_i[k*DW-1 -: DW];
   end

   always_comb begin
      valid_o = 1'b0;
      value_o = '0;
      for (int k = 1; k <= NSRC; k++) begin
         if (code_i == CODE_W'(k)) begin
            valid_o = 1'b1;
            value_o = cand[k];
         end
      end
   end
endmodule

// File: rtl/dta_history.sv
module dta_history #(
   parameter int DW     = 14,
   parameter int DEPTH  = 256,
   parameter int SPAN_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DW-1:0]     din_i,
   input  logic [SPAN_W-1:0] span_i,
   output logic [DW-1:0]     old_o,
   output logic              ready_o
);
   localparam int AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH) begin : g_chk_pow2
      $error("history depth must be a power of two");
   end
   if (DEPTH < (1 << SPAN_W) - 1) begin : g_chk_depth
      $error("history depth shorter than the largest span");
   end
   if (AW + 1 < SPAN_W) begin : g_chk_width
      $error("span wider than the fill counter");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp;
   logic [AW:0]   fill;
   logic [AW:0]   n_ext;
   logic [AW-1:0] rd_idx;

   assign n_ext   = (span_i < SPAN_W'(2)) ? (AW+1)'(1) : (AW+1)'(span_i);
   assign rd_idx  = wp - n_ext[AW-1:0];
   assign old_o   = mem[rd_idx];
   assign ready_o = (fill >= n_ext);

   always_ff @(posedge clk) begin
      if (push_i) mem[wp] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         fill <= '0;
      end else if (push_i) begin
         wp <= wp + 1'b1;
         if (fill != (AW+1)'(DEPTH)) fill <= fill + 1'b1;
      end
   end

   // R4: the recorded-sample count only grows between resets and never exceeds the depth
   a_r4_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fill >= $past(fill)) && (fill <= (AW+1)'(DEPTH)));
endmodule

// File: rtl/dta_channel.sv
module dta_channel
   import dta_pkg::*;
#(
   parameter int DW          = 14,
   parameter int NSRC        = 11,
   parameter int DEPTH       = 256,
   parameter int SPAN_W      = 8,
   parameter bit RATE_SUPPORT = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_i,
   input  logic [NSRC*DW-1:0] raw_i,
   input  logic [NSRC*DW-1:0] filt_i,
   input  logic [CODE_W-1:0]  code_i,
   input  logic               filt_sel_i,
   input  logic               rate_i,
   input  logic [SPAN_W-1:0]  span_i,
   input  logic [15:0]        thr_i,
   input  logic               clr_i,
   output logic               flag_o
);
   logic          src_ok;
   logic [DW-1:0] cur;
   logic [DW-1:0] old;
   logic          ready;

   dta_src_mux #(.DW(DW), .NSRC(NSRC)) u_mux (
      .raw_i(raw_i), .filt_i(filt_i), .code_i(code_i), .filt_sel_i(filt_sel_i),
      .valid_o(src_ok), .value_o(cur)
   );

   if (RATE_SUPPORT) begin : g_rate
      dta_history #(.DW(DW), .DEPTH(DEPTH), .SPAN_W(SPAN_W)) u_hist (
         .clk(clk), .rst_n(rst_n), .push_i(sample_i), .din_i(cur),
         .span_i(span_i), .old_o(old), .ready_o(ready)
      );
   end else begin : g_level_only
      assign old   = '0;
      assign ready = 1'b0;
      logic [SPAN_W-1:0] unused_span;
      assign unused_span = span_i;
   end

   logic signed [DW:0] cur_s, old_s, metric, lim;
   logic armed, beyond, hit;
   logic [15-DW:0] unused_thr;

   assign unused_thr = thr_i[14:DW];
   assign cur_s  = {cur[DW-1], cur};
   assign old_s  = {old[DW-1], old};
   assign lim    = {thr_i[DW-1], thr_i[DW-1:0]};
   assign metric = rate_i ? (cur_s - old_s) : cur_s;
   assign armed  = src_ok && (!rate_i || ready);
   assign beyond = thr_i[THR_DIR_BIT] ? (metric > lim) : (metric < lim);
   assign hit    = sample_i && armed && beyond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= (flag_o && !clr_i) || hit;
   end

   // R1: a disabled monitor never raises its flag
   a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == SRC_OFF && !flag_o) |=> !flag_o);
   // R6: a read with no sample in the same cycle leaves the flag clear
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !sample_i) |=> !flag_o);
   // R7: a set flag survives until a read
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/dual_threshold_alarm.sv
module dual_threshold_alarm
   import dta_pkg::*;
#(
   parameter int DW           = 14,
   parameter int NSRC         = 11,
   parameter int HIST_DEPTH   = 256,
   parameter int SPAN_W       = 8,
   parameter bit RATE_SUPPORT = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_valid_i,
   input  logic [NSRC*DW-1:0] src_raw_i,
   input  logic [NSRC*DW-1:0] src_filt_i,
   input  logic [15:0]        ctrl_i,
   input  logic [15:0]        thr_a_i,
   input  logic [15:0]        thr_b_i,
   input  logic [SPAN_W-1:0]  span_a_i,
   input  logic [SPAN_W-1:0]  span_b_i,
   input  logic               status_rd_i,
   output logic [15:0]        status_o,
   output logic [1:0]         alarm_line_o
);
   localparam int NCH = 2;

   if (DW < 2 || DW > 14) begin : g_chk_dw
      $error("sample width must lie between 2 and 14 bits");
   end
   if (NSRC < 1 || NSRC > 15) begin : g_chk_nsrc
      $error("source count must fit a 4-bit code");
   end

   logic [CODE_W-1:0] code [NCH];
   logic [NCH-1:0]    rate_en;
   logic [15:0]       thr  [NCH];
   logic [SPAN_W-1:0] span [NCH];
   logic [NCH-1:0]    flag;
   logic [1:0]        unused_ctrl;

   assign unused_ctrl = {ctrl_i[5], ctrl_i[3]};
   assign code[0]    = ctrl_i[CF_SRC_A_LO +: CODE_W];
   assign code[1]    = ctrl_i[CF_SRC_B_LO +: CODE_W];
   assign rate_en[0] = ctrl_i[CF_RATE_A];
   assign rate_en[1] = ctrl_i[CF_RATE_B];
   assign thr[0]     = thr_a_i;
   assign thr[1]     = thr_b_i;
   assign span[0]    = span_a_i;
   assign span[1]    = span_b_i;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dta_channel #(
         .DW(DW), .NSRC(NSRC), .DEPTH(HIST_DEPTH), .SPAN_W(SPAN_W),
         .RATE_SUPPORT(RATE_SUPPORT)
      ) u_ch (
         .clk(clk), .rst_n(rst_n), .sample_i(sample_valid_i),
         .raw_i(src_raw_i), .filt_i(src_filt_i), .code_i(code[c]),
         .filt_sel_i(ctrl_i[CF_FILT]), .rate_i(rate_en[c]), .span_i(span[c]),
         .thr_i(thr[c]), .clr_i(status_rd_i), .flag_o(flag[c])
      );
   end

   always_comb begin
      status_o             = '0;
      status_o[STAT_BIT_A] = flag[0];
      status_o[STAT_BIT_B] = flag[1];
   end

   logic any_hit, level;
   assign any_hit = |flag;
   assign level   = ctrl_i[CF_OUT_POL] ? any_hit : !any_hit;

   always_comb begin
      alarm_line_o = 2'b00;
      if (ctrl_i[CF_OUT_EN]) alarm_line_o[ctrl_i[CF_OUT_SEL]] = level;
   end

   // R8: with output enabled and no flag set, the chosen line rests at its inactive level
   a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_i[CF_OUT_EN] && status_o[STAT_BIT_A] == 1'b0 && status_o[STAT_BIT_B] == 1'b0)
      |-> alarm_line_o[ctrl_i[CF_OUT_SEL]] == !ctrl_i[CF_OUT_POL]);
   // R5: flags appear only one edge after a strobe that could set them
   a_r5_set_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[STAT_BIT_A]) |-> $past(sample_valid_i));
endmodule

// File: tb/dual_threshold_alarm_tb_top.sv
`timescale 1ns/1ps
module dual_threshold_alarm_tb_top;
   localparam int DW = 14, NSRC = 11, SPAN_W = 8, DEPTH = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sv = 1'b0;
   logic [NSRC*DW-1:0] raw_flat = '0, filt_flat = '0;
   logic [15:0] ctrl = '0, thr_a = '0, thr_b = '0;
   logic [SPAN_W-1:0] span_a = '0, span_b = '0;
   logic rd = 1'b0;
   logic [15:0] status;
   logic [1:0]  line;

   always #2 clk = ~clk;

   dual_threshold_alarm dut_i (
      .clk(clk), .rst_n(rst_n), .sample_valid_i(sv), .src_raw_i(raw_flat),
      .src_filt_i(filt_flat), .ctrl_i(ctrl), .thr_a_i(thr_a), .thr_b_i(thr_b),
      .span_a_i(span_a), .span_b_i(span_b), .status_rd_i(rd),
      .status_o(status), .alarm_line_o(line)
   );

   int rawv [1:NSRC];
   int filv [1:NSRC];
   int hist [2][DEPTH];
   int wp [2];
   int fill [2];
   bit eflag [2];
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   function automatic int sx14(input logic [13:0] v);
      return int'($signed(v));
   endfunction

   task automatic model_reset();
      for (int a = 0; a < 2; a++) begin
         wp[a] = 0; fill[a] = 0; eflag[a] = 0;
      end
   endtask

   task automatic pack_src();
      for (int k = 1; k <= NSRC; k++) begin
         raw_flat[(k-1)*DW +: DW]  = 14'(rawv[k]);
         filt_flat[(k-1)*DW +: DW] = 14'(filv[k]);
      end
   endtask

   task automatic check(input string tag);
      logic [15:0] es;
      logic [1:0]  el;
      bit any, lvl;
      es = '0; es[8] = eflag[0]; es[9] = eflag[1];
      any = eflag[0] | eflag[1];
      lvl = ctrl[1] ? any : !any;
      el = 2'b00;
      if (ctrl[2]) el[ctrl[0]] = lvl;
      n_cmp++;
      if (status !== es) begin
         n_bad++;
         $display("FAIL %s status actual=%h expected=%h", tag, status, es);
      end
      n_cmp++;
      if (line !== el) begin
         n_bad++;
         $display("FAIL %s line actual=%b expected=%b", tag, line, el);
      end
   endtask

   // inputs already set (after a falling edge); predict the next rising edge, then check
   task automatic tick(input string tag);
      bit hit [2];
      for (int a = 0; a < 2; a++) begin
         int code, cur, n, metric, lim;
         bit rate, ok;
         logic [15:0] th;
         code = (a == 0) ? int'(ctrl[11:8]) : int'(ctrl[15:12]);
         rate = (a == 0) ? ctrl[6] : ctrl[7];
         th   = (a == 0) ? thr_a : thr_b;
         n    = (a == 0) ? int'(span_a) : int'(span_b);
         if (n < 2) n = 1;
         ok   = (code >= 1 && code <= NSRC);
         cur  = 0;
         if (ok) cur = sx14(14'((ctrl[4] || code == 9 || code == 10) ? filv[code] : rawv[code]));
         hit[a] = 0;
         if (sv && ok) begin
            metric = cur;
            if (rate) begin
               if (fill[a] < n) ok = 0;
               else metric = cur - hist[a][(wp[a] - n) & (DEPTH-1)];
            end
            lim = sx14(th[13:0]);
            if (ok) hit[a] = th[15] ? (metric > lim) : (metric < lim);
         end
         if (sv) begin
            hist[a][wp[a]] = cur;
            wp[a] = (wp[a] + 1) & (DEPTH-1);
            if (fill[a] < DEPTH) fill[a]++;
         end
         eflag[a] = (rd ? 1'b0 : eflag[a]) | hit[a];
      end
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   task automatic rand_src(input int range);
      for (int k = 1; k <= NSRC; k++) begin
         rawv[k] = int'($urandom_range(2*range)) - range;
         filv[k] = int'($urandom_range(2*range)) - range;
      end
      pack_src();
   endtask

   function automatic logic [15:0] mk_thr(input bit gt, input int lvl);
      return {gt, 1'b0, 14'(lvl)};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      sv = 0; rd = 0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5A17));
      for (int k = 1; k <= NSRC; k++) begin rawv[k] = 0; filv[k] = 0; end
      pack_src();
      model_reset();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9");

      // R4: rate mode, span 4, ramp +100 per strobe, alarm when change > 300
      ctrl = 16'h0240 | 16'h0006; span_a = 8'd4; thr_a = mk_thr(1'b1, 300);
      for (int i = 0; i < 8; i++) begin
         rawv[2] = i * 100; pack_src(); sv = 1; tick("R4");
      end
      rd = 1; sv = 0; tick("R6"); rd = 0;
      // R4: span 0 and span 1 behave alike (step of 60 over one sample)
      for (int s = 0; s < 2; s++) begin
         span_a = 8'(s); thr_a = mk_thr(1'b1, 50);
         rawv[2] = 0; pack_src(); sv = 1; tick("R4");
         rawv[2] = 60; pack_src(); tick("R4");
         rd = 1; sv = 0; tick("R4"); rd = 0;
      end

      // R1: disabled codes with a threshold every value would cross
      for (int c = 0; c < 16; c += 12) begin
         ctrl = {4'(c), 4'(c), 8'h06}; thr_a = mk_thr(1'b0, 8000); thr_b = mk_thr(1'b0, 8000);
         for (int i = 0; i < 4; i++) begin rand_src(200); sv = 1; tick("R1"); end
      end
      ctrl = {4'd15, 4'd13, 8'h06};
      for (int i = 0; i < 4; i++) begin rand_src(200); sv = 1; tick("R1"); end

      // R2: incline source forced to filtered copy; code 3 follows the select bit
      ctrl = {4'd3, 4'd9, 8'h06}; thr_a = mk_thr(1'b1, 1000); thr_b = mk_thr(1'b1, 1000);
      rawv[9] = 10; filv[9] = 2000; rawv[3] = 10; filv[3] = 2000; pack_src();
      sv = 1; tick("R2");
      rd = 1; sv = 0; tick("R2"); rd = 0;
      ctrl[4] = 1'b1; sv = 1; tick("R2");
      rd = 1; sv = 0; tick("R2"); rd = 0;

      // R6: read and a true condition in the same cycle keeps the flag set
      ctrl = {4'd0, 4'd5, 8'h06}; thr_a = mk_thr(1'b0, 0);
      rawv[5] = -5; pack_src(); sv = 1; tick("R6");
      rd = 1; tick("R6");
      sv = 0; tick("R6"); rd = 0;
      sv = 0; tick("R7");

      // R8: every enable / polarity / select combination, with and without a flag
      for (int m = 0; m < 8; m++) begin
         ctrl = {4'd0, 4'd5, 5'b0, 3'(m)}; rawv[5] = -5; pack_src();
         sv = 1; tick("R8");
         rd = 1; sv = 0; tick("R8"); rd = 0;
      end

      // R4: a reset empties the history again
      do_reset();
      check("R9");
      ctrl = 16'h0240 | 16'h0004; span_a = 8'd3; thr_a = mk_thr(1'b1, -100);
      for (int i = 0; i < 5; i++) begin rand_src(50); sv = 1; tick("R4"); end

      // random mix: R3 level mode, R4 rate mode, R5/R7 flag placement and stickiness
      for (int blk = 0; blk < 60; blk++) begin
         string tag;
         ctrl = 16'($urandom());
         ctrl[15:12] = 4'($urandom_range(12));
         ctrl[11:8]  = 4'($urandom_range(12));
         thr_a = mk_thr(1'($urandom()), int'($urandom_range(600)) - 300);
         thr_b = mk_thr(1'($urandom()), int'($urandom_range(600)) - 300);
         span_a = 8'($urandom_range(20));
         span_b = 8'($urandom_range(300) > 250 ? $urandom_range(255) : $urandom_range(6));
         case (blk % 3)
            0: begin ctrl[7:6] = 2'b00; tag = "R3"; end
            1: tag = "R4";
            default: tag = "R5";
         endcase
         for (int i = 0; i < 60; i++) begin
            rand_src(300);
            sv = ($urandom_range(3) != 0);
            rd = ($urandom_range(7) == 0);
            tick(rd ? "R6" : (eflag[0] | eflag[1]) ? "R7" : tag);
         end
      end
      sv = 0; rd = 0;

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule